// File: doc/BRIEF.md
# Nibble-Wide Ethernet Transmit Handshake

This block takes 4-bit transmit data from an external Ethernet frame source and hands it to a downstream buffer. It raises a read request when it can accept data. The source answers with an enable line, and each nibble shows up on the data bus a fixed two clocks after the enable cycle it belongs to. The block delays the enable through a short shift register so that the data and its validity line up. It captures one nibble for each enable cycle and presents it on a registered output, with markers for the first and last nibble of a frame.

Flow control comes from the downstream buffer's almost-full line. While the source is enabled, raising almost-full drops the read request on the next clock. Nibbles already inside the latency window are still captured, so none are lost. When the enable falls, the read request keeps the value it had for a hold window of two cycles. It cannot rise again until that window has passed. A frame that ends while backpressure is applied is closed normally, with an end marker on its last nibble.

Top module: `nibtx_handshake`

## Requirements
- R1: While `rst_n` is low, `rd_req` and `out_valid` are 0. The enable delay line is cleared, so no beat appears after release unless a new enable is sampled.
- R2: If no hold window is active and `sink_afull` is 0, `rd_req` is 1 in the cycle after any clock edge, including the first edge after reset release.
- R3: An enable sampled high at edge k causes `src_nib` to be captured at edge k+2. The captured nibble shows on `out_nib` with `out_valid`=1 in the cycle after that capture edge. There is one beat per enable cycle, in order.
- R4: `out_sof` is 1 on the first beat of each run of consecutive enable cycles, and 0 on every other beat.
- R5: `out_eof` is 1 on the last beat of each run of consecutive enable cycles, and 0 on every other beat. A one-nibble frame carries both markers.
- R6: If `src_en` and `sink_afull` are both 1 at an edge, `rd_req` is 0 in the following cycle. Every nibble belonging to enable cycles that were already sampled is still delivered.
- R7: If `rd_req` is 1 in the first cycle with `src_en` low after a high cycle, it stays 1 in the next cycle too. That makes two cycles, whatever `sink_afull` does.
- R8: If `rd_req` is 0 in the first cycle with `src_en` low after a high cycle, it stays 0 in the next cycle, even if `sink_afull` has been cleared.
- R9: A frame whose enable falls while `rd_req` is held low by backpressure ends with `out_eof` on its last nibble, and no nibble is missing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| src_nib | input | 4 | Nibble data from the frame source |
| src_en | input | 1 | Source enable, answering the read request |
| sink_afull | input | 1 | Downstream buffer almost full |
| rd_req | output | 1 | Read request to the source |
| out_valid | output | 1 | A captured nibble is present on `out_nib` |
| out_nib | output | 4 | Captured nibble |
| out_sof | output | 1 | First nibble of a frame |
| out_eof | output | 1 | Last nibble of a frame |

## Verification
The bench builds the block with its default values: a data latency of 2, a hold window of 2 and a 4-bit data path. With a hold of 2, the hold counter is loaded with zero. The single held decision is then the whole window, so a request that is cleared or reasserted one cycle too early shows up as a one-cycle difference at `rd_req`. With a latency of 2, the enable and data patterns overlap: the enable for the next nibble is already up while the current one is captured. This exercises marker placement for one-nibble frames, for longer frames, and for frames cut short by reset.

// File: rtl/nibtx_pkg.sv
package nibtx_pkg;

  // Frame delimiter pair carried alongside each captured nibble
  typedef struct packed {
    logic sof;
    logic eof;
  } frame_mark_t;

  // Width of a down-counter that must hold values up to n-1
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 3) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/nibtx_en_pipe.sv
module nibtx_en_pipe #(
  parameter int unsigned LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_en,
  output logic take,
  output logic last
);

  logic [LAT-1:0] stage_q;
  logic [LAT-1:0] stage_d;
  logic           nxt;

  generate
    if (LAT == 1) begin : g_lat1
      assign stage_d = src_en;
      assign nxt     = src_en;
    end else begin : g_latn
      assign stage_d = {stage_q[LAT-2:0], src_en};
      assign nxt     = stage_q[LAT-2];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  // Capture when the enable of LAT edges ago is present; last when the
  // following enable is absent
  assign take = stage_q[LAT-1];
  assign last = stage_q[LAT-1] & ~nxt;

endmodule

// File: rtl/nibtx_req_ctrl.sv
module nibtx_req_ctrl #(
  parameter int unsigned HOLD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_en,
  input  logic sink_afull,
  output logic rd_req
);
  import nibtx_pkg::*;

  localparam int unsigned CW = cnt_w(HOLD);
  localparam logic [CW-1:0] LOAD = CW'(HOLD - 2);

  logic          en_q;
  logic          req_q, req_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          fall;

  assign fall = en_q & ~src_en;

  always_comb begin
    req_d = req_q;
    cnt_d = cnt_q;
    if (src_en) begin
      req_d = ~sink_afull;
      cnt_d = '0;
    end else if (fall) begin
      cnt_d = LOAD;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end else begin
      req_d = ~sink_afull;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      req_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      en_q  <= src_en;
      req_q <= req_d;
      cnt_q <= cnt_d;
    end
  end

  assign rd_req = req_q;

  AST_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    (src_en && sink_afull) |=> !rd_req); // R6
  AST_HOLD_KEEPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(src_en) && !src_en && rd_req) |=> rd_req); // R7
  AST_NO_EARLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(src_en) && !src_en && !rd_req) |=> !rd_req); // R8

endmodule

// File: rtl/nibtx_capture.sv
module nibtx_capture #(
  parameter int unsigned DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          last,
  input  logic [DW-1:0] src_nib,
  output logic          out_valid,
  output logic [DW-1:0] out_nib,
  output logic          out_sof,
  output logic          out_eof
);
  import nibtx_pkg::*;

  logic          valid_q;
  logic          prev_q;
  logic [DW-1:0] data_q, data_d;
  frame_mark_t   mark_q, mark_d;

  always_comb begin
    data_d     = take ? src_nib : data_q;
    mark_d.sof = take & ~prev_q;
    mark_d.eof = last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      prev_q  <= 1'b0;
      data_q  <= '0;
      mark_q  <= '0;
    end else begin
      valid_q <= take;
      prev_q  <= take;
      data_q  <= data_d;
      mark_q  <= mark_d;
    end
  end

  assign out_valid = valid_q;
  assign out_nib   = data_q;
  assign out_sof   = mark_q.sof;
  assign out_eof   = mark_q.eof;

  AST_TAKE_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid); // R3
  AST_SOF_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid); // R4
  AST_EOF_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> out_valid); // R5
  AST_EOF_THEN_SOF: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_eof) |=> (!out_valid || out_sof)); // R4

endmodule

// File: rtl/nibtx_handshake.sv
module nibtx_handshake #(
  parameter int unsigned DW   = 4,
  parameter int unsigned LAT  = 2,
  parameter int unsigned HOLD = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] src_nib,
  input  logic          src_en,
  input  logic          sink_afull,
  output logic          rd_req,
  output logic          out_valid,
  output logic [DW-1:0] out_nib,
  output logic          out_sof,
  output logic          out_eof
);

  logic take;
  logic last;

  nibtx_req_ctrl #(.HOLD(HOLD)) u_req (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_en     (src_en),
    .sink_afull (sink_afull),
    .rd_req     (rd_req)
  );

  nibtx_en_pipe #(.LAT(LAT)) u_pipe (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_en (src_en),
    .take   (take),
    .last   (last)
  );

  nibtx_capture #(.DW(DW)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .last      (last),
    .src_nib   (src_nib),
    .out_valid (out_valid),
    .out_nib   (out_nib),
    .out_sof   (out_sof),
    .out_eof   (out_eof)
  );

  AST_NO_VALID_IN_RESET: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && !rd_req)); // R1

endmodule

// File: tb/tb_nibtx_handshake.sv
module tb_nibtx_handshake;

  logic       clk;
  logic       rst_n;
  logic [3:0] src_nib;
  logic       src_en;
  logic       sink_afull;
  logic       rd_req;
  logic       out_valid;
  logic [3:0] out_nib;
  logic       out_sof;
  logic       out_eof;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic       rq [0:63];
  logic       ov [0:63];
  logic [3:0] od [0:63];
  logic       os [0:63];
  logic       oe [0:63];

  nibtx_handshake dut (
    .clk(clk), .rst_n(rst_n), .src_nib(src_nib), .src_en(src_en),
    .sink_afull(sink_afull), .rd_req(rd_req), .out_valid(out_valid),
    .out_nib(out_nib), .out_sof(out_sof), .out_eof(out_eof)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [3:0] nib(input logic [3:0] seed, input int k);
    return 4'(seed + 3 * k + (k >> 2));
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Source model: enable for n cycles, data two cycles later
  task automatic run_frame(input int n, input logic [3:0] seed,
                           input int af_on, input int af_off);
    for (int i = 0; i < n + 6; i++) begin
      @(negedge clk);
      rq[i] = rd_req;  ov[i] = out_valid; od[i] = out_nib;
      os[i] = out_sof; oe[i] = out_eof;
      src_en  = (i < n);
      src_nib = (i >= 2 && i - 2 < n) ? nib(seed, i - 2) : 4'h0;
      if (i == af_on)  sink_afull = 1'b1;
      if (i == af_off) sink_afull = 1'b0;
    end
    src_en = 1'b0;
    sink_afull = 1'b0;
  endtask

  task automatic check_beats(input int n, input logic [3:0] seed, input string req);
    int k = 0;
    for (int i = 0; i < n + 6; i++) begin
      if (ov[i]) begin
        chk(req, "nibble", od[i], nib(seed, k));
        chk("R4", "sof", os[i], (k == 0));
        chk("R5", "eof", oe[i], (k == n - 1));
        k++;
      end
    end
    chk(req, "beat count", k, n);
  endtask

  task automatic test_reset();
    rst_n = 1'b0; src_en = 1'b0; src_nib = 4'h0; sink_afull = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "rd_req in reset", rd_req, 0);
    chk("R1", "out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2", "rd_req after release", rd_req, 1);
  endtask

  task automatic test_basic();
    run_frame(8, 4'h5, -1, -1);
    chk("R3", "valid before latency", ov[2], 0);
    chk("R3", "valid at latency", ov[3], 1);
    chk("R2", "rd_req idle", rq[12], 1);
    check_beats(8, 4'h5, "R3");
  endtask

  task automatic test_single();
    run_frame(1, 4'hA, -1, -1);
    chk("R5", "single beat valid", ov[3], 1);
    chk("R5", "single beat sof", os[3], 1);
    chk("R5", "single beat eof", oe[3], 1);
    check_beats(1, 4'hA, "R3");
  endtask

  task automatic test_backpressure();
    run_frame(6, 4'h2, 2, 6);
    chk("R6", "rd_req before afull", rq[2], 1);
    chk("R6", "rd_req dropped", rq[3], 0);
    chk("R8", "rd_req low at fall", rq[6], 0);
    chk("R8", "no early reassert", rq[7], 0);
    chk("R8", "reassert after hold", rq[8], 1);
    check_beats(6, 4'h2, "R9");
  endtask

  task automatic test_hold();
    run_frame(5, 4'hC, 5, -1);
    chk("R7", "rd_req first low cycle", rq[5], 1);
    chk("R7", "rd_req held", rq[6], 1);
    chk("R6", "rd_req drops after hold", rq[7], 0);
    check_beats(5, 4'hC, "R3");
  endtask

  task automatic test_reset_midframe();
    int seen = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      src_en = 1'b1; src_nib = 4'h9;
    end
    @(negedge clk);
    rst_n = 1'b0; src_en = 1'b0;
    @(negedge clk);
    chk("R1", "rd_req mid-frame reset", rd_req, 0);
    chk("R1", "out_valid mid-frame reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2", "rd_req after mid reset", rd_req, 1);
    for (int i = 0; i < 5; i++) begin
      if (out_valid) seen++;
      @(negedge clk);
    end
    chk("R1", "stale beats after reset", seen, 0);
  endtask

  initial begin
    test_reset();
    test_basic();
    test_single();
    test_backpressure();
    test_hold();
    test_reset_midframe();
    test_basic();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule